// File: doc/BRIEF.md
# Supply Supervisor Status Logic

This block is the digital half of a two-level supply supervisor. Two analog comparators report whether the supply is below the reset level and whether it is below the low-supply warning level. From those two inputs the block drives an active-low reset output and keeps two sticky status flags, one for each fault. Software reads the flags through a one-cycle read strobe, and a read clears a flag once its fault has gone away.

A small configuration word selects the reset threshold (high or low level) and picks which of two enable bits keeps the reset comparator on. A power-mode input turns the low-supply comparator off in sleep. While it is off, the low-supply flag holds its value, but a read still clears it.

After the supply recovers, the reset output is held low for a fixed number of ticks of a slow clock. If the supply dips again during that hold, the count starts over.

Top module: `supply_sup`

## Requirements
- R1: After `rstN` is released, `rdData` is 0, `rstOutN` is 1, `thrLowSel` is 0 (high threshold), `rstMonOn` is 1, and with `mode`=0 `lvdMonOn` is 1.
- R2: While `rstMonOn` and `belowRst` are both 1, `rstOutN` is 0 in the same cycle, and `rdData[0]` (the reset flag) is 1 after the next clock edge.
- R3: With `mode` not equal to 3 and `belowLvd`=1, `rdData[1]` (the low-supply flag) is 1 after the next clock edge.
- R4: After the last cycle in which the reset fault is present, `rstOutN` stays 0 for exactly `HOLD_TICKS` more clock cycles. A new fault during the hold restarts the full hold.
- R5: In modes 0 to 2, a cycle with `rdStb`=1 clears a flag at the next edge only if the matching fault is absent in that cycle. Without a read, a flag stays at 1.
- R6: A fault and a read in the same cycle leave the flag at 1, because set wins over clear.
- R7: In `mode`=3 (sleep), `lvdMonOn` is 0, `belowLvd` is ignored, and `rdData[1]` keeps its value unless a read occurs.
- R8: In `mode`=3, a read clears `rdData[1]` at the next edge, whatever the value of `belowLvd`.
- R9: `wrStb` loads `wrData` at the clock edge. Bit 0 is the low-threshold select and drives `thrLowSel`. Bit 1 is the monitor select. Bits 2 and 3 are the two reset-monitor enables. `rstMonOn` equals bit 3 when bit 1 is set and bit 2 otherwise. The reset value of the word is 4'b1100. While `rstMonOn` is 0, `belowRst` sets no flag and holds no reset.
- R10: Over a long mixed stream of faults, reads, writes and mode changes, every output matches the cycle model stated in R1 to R9 (mode codes: 0 run, 1 idle, 2 standby, 3 sleep).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow supervisor clock (32.768 kHz in use) |
| rstN | input | 1 | Power-on reset, active low |
| belowRst | input | 1 | Comparator: supply below the reset threshold |
| belowLvd | input | 1 | Comparator: supply below the low-supply threshold |
| mode | input | 2 | Power mode: 0 run, 1 idle, 2 standby, 3 sleep |
| rdStb | input | 1 | One-cycle status read strobe |
| wrStb | input | 1 | Configuration write strobe |
| wrData | input | 4 | Configuration word to write |
| rdData | output | 2 | Status flags: bit 0 reset, bit 1 low-supply |
| rstOutN | output | 1 | Stretched active-low reset output |
| thrLowSel | output | 1 | Reset comparator threshold select (1 = low level) |
| rstMonOn | output | 1 | Reset comparator enable |
| lvdMonOn | output | 1 | Low-supply comparator enable |

## Verification
The assertions assume that the comparator inputs are already synchronous to `clk` and stable across each edge, and that the read strobe is one clock cycle long, with no other timing relation to the faults. They also assume `mode` changes only at clock edges. The bench meets these assumptions by driving every input at the falling edge from a fixed-seed random stream. Fault inputs come in bursts, so hold restarts happen often, and configuration writes are rare, so the reset monitor spends long stretches both on and off.

// File: rtl/supsup_pkg.sv
package supsup_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_STANDBY = 2'd2,
    MODE_SLEEP   = 2'd3
  } pwrMode_t;

  // Configuration word, MSB first
  typedef struct packed {
    logic en1;
    logic en0;
    logic monSel;
    logic thrLow;
  } supCfg_t;

  localparam supCfg_t CFG_RESET = '{en1: 1'b1, en0: 1'b1, monSel: 1'b0, thrLow: 1'b0};

  // Strobes from control to datapath
  typedef struct packed {
    logic setRst;
    logic clrRst;
    logic setLvd;
    logic clrLvd;
    logic holdLoad;
  } supStrobe_t;
endpackage

// File: rtl/supsup_ctrl.sv
module supsup_ctrl
  import supsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       belowRst,
  input  logic       belowLvd,
  input  logic [1:0] mode,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [3:0] wrData,
  output supStrobe_t strb,
  output logic       thrLowSel,
  output logic       rstMonOn,
  output logic       lvdMonOn
);
  supCfg_t  cfgQ;
  pwrMode_t modeCur;
  logic     rstFault;
  logic     lvdFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= CFG_RESET;
    else if (wrStb) cfgQ <= supCfg_t'(wrData);
  end

  always_comb begin
    modeCur   = pwrMode_t'(mode);
    thrLowSel = cfgQ.thrLow;
    rstMonOn  = cfgQ.monSel ? cfgQ.en1 : cfgQ.en0;
    lvdMonOn  = (modeCur != MODE_SLEEP);
    rstFault  = rstMonOn && belowRst;
    lvdFault  = lvdMonOn && belowLvd;
    strb.setRst   = rstFault;
    strb.clrRst   = rdStb && !rstFault;
    strb.setLvd   = lvdFault;
    // in sleep the comparator is off, so a read always clears
    strb.clrLvd   = rdStb && !lvdFault;
    strb.holdLoad = rstFault;
  end
endmodule

// File: rtl/supsup_dp.sv
module supsup_dp
  import supsup_pkg::*;
#(
  parameter int HOLD_TICKS = 50463
) (
  input  logic       clk,
  input  logic       rstN,
  input  supStrobe_t strb,
  output logic [1:0] rdData,
  output logic       rstOutN
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_TICKS);

  logic             rstFlag;
  logic             lvdFlag;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstFlag <= 1'b0;
      lvdFlag <= 1'b0;
    end else begin
      rstFlag <= strb.setRst || (rstFlag && !strb.clrRst);
      lvdFlag <= strb.setLvd || (lvdFlag && !strb.clrLvd);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strb.holdLoad)   holdCnt <= HOLD_VAL;
    else if (holdCnt != '0)   holdCnt <= holdCnt - CNT_W'(1);
  end

  assign rdData  = {lvdFlag, rstFlag};
  assign rstOutN = !(strb.holdLoad || (holdCnt != '0));
endmodule

// File: rtl/supply_sup.sv
module supply_sup
  import supsup_pkg::*;
#(
  parameter int HOLD_TICKS = 50463
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       belowRst,
  input  logic       belowLvd,
  input  logic [1:0] mode,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [3:0] wrData,
  output logic [1:0] rdData,
  output logic       rstOutN,
  output logic       thrLowSel,
  output logic       rstMonOn,
  output logic       lvdMonOn
);
  supStrobe_t strb;

  supsup_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .belowRst(belowRst), .belowLvd(belowLvd),
    .mode(mode), .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData),
    .strb(strb), .thrLowSel(thrLowSel), .rstMonOn(rstMonOn), .lvdMonOn(lvdMonOn)
  );

  supsup_dp #(.HOLD_TICKS(HOLD_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData), .rstOutN(rstOutN)
  );
endmodule

// File: rtl/supply_sup_chk.sv
module supply_sup_chk (
  input logic       clk,
  input logic       rstN,
  input logic       belowRst,
  input logic       belowLvd,
  input logic [1:0] mode,
  input logic       rdStb,
  input logic [1:0] rdData,
  input logic       rstOutN,
  input logic       rstMonOn,
  input logic       lvdMonOn
);
  AST_FAULT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (rstMonOn && belowRst) |-> !rstOutN); // R2
  AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rstMonOn && belowRst) |=> rdData[0]); // R2
  AST_LVD_SET: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd3 && belowLvd) |=> rdData[1]); // R3
  AST_HOLD_START: assert property (@(posedge clk) disable iff (!rstN)
    (rstMonOn && belowRst) |=> !rstOutN); // R4
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && !rdStb) |=> rdData[0]); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (rstMonOn && belowRst && rdStb) |=> rdData[0]); // R6
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |-> !lvdMonOn); // R7
  AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && !rdStb) |=> $stable(rdData[1])); // R7
  AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && rdStb) |=> !rdData[1]); // R8
endmodule

bind supply_sup supply_sup_chk u_chk (
  .clk(clk), .rstN(rstN), .belowRst(belowRst), .belowLvd(belowLvd),
  .mode(mode), .rdStb(rdStb), .rdData(rdData), .rstOutN(rstOutN),
  .rstMonOn(rstMonOn), .lvdMonOn(lvdMonOn)
);

// File: tb/supply_sup_test.sv
module supply_sup_test;
  localparam int HOLD = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       belowRst = 1'b0, belowLvd = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] wrData = 4'd0;
  logic [1:0] rdData;
  logic       rstOutN, thrLowSel, rstMonOn, lvdMonOn;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  bit mRst, mLvd;
  bit [3:0] mCfg;
  int mCnt;

  always #10 clk = ~clk;

  supply_sup #(.HOLD_TICKS(HOLD)) uut (
    .clk(clk), .rstN(rstN), .belowRst(belowRst), .belowLvd(belowLvd),
    .mode(mode), .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData),
    .rdData(rdData), .rstOutN(rstOutN), .thrLowSel(thrLowSel),
    .rstMonOn(rstMonOn), .lvdMonOn(lvdMonOn)
  );

  function automatic bit monOn(bit [3:0] c);
    return c[1] ? c[3] : c[2];
  endfunction
  function automatic bit rstFlt();
    return monOn(mCfg) && belowRst;
  endfunction
  function automatic bit lvdFlt();
    return (mode != 2'd3) && belowLvd;
  endfunction
  function automatic bit expRstOutN();
    return !(rstFlt() || mCnt != 0);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    chk({tag, " rdData"}, rdData, {mLvd, mRst});
    chk({tag, " rstOutN"}, rstOutN, expRstOutN());
    chk({tag, " thrLowSel"}, thrLowSel, mCfg[0]);
    chk({tag, " rstMonOn"}, rstMonOn, monOn(mCfg));
    chk({tag, " lvdMonOn"}, lvdMonOn, mode != 2'd3);
  endtask

  task automatic modelStep();
    bit rf, lf;
    rf = rstFlt();
    lf = lvdFlt();
    mRst = rf || (mRst && !(rdStb && !rf));
    mLvd = lf || (mLvd && !(rdStb && !lf));
    if (rf) mCnt = HOLD;
    else if (mCnt != 0) mCnt--;
    if (wrStb) mCfg = wrData;
  endtask

  task automatic cyc(bit bR, bit bL, bit rd, bit wr, bit [3:0] wd, bit [1:0] md, string tag);
    @(negedge clk);
    belowRst = bR; belowLvd = bL; rdStb = rd; wrStb = wr; wrData = wd; mode = md;
    #5 checkAll(tag);
    @(posedge clk);
    #1 modelStep();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mRst = 0; mLvd = 0; mCfg = 4'b1100; mCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #5;
    // R1 literal reset state
    chk("R1 rdData", rdData, 0);
    chk("R1 rstOutN", rstOutN, 1);
    chk("R1 thrLowSel", thrLowSel, 0);
    chk("R1 rstMonOn", rstMonOn, 1);
    chk("R1 lvdMonOn", lvdMonOn, 1);

    // R2 fault drives reset low and sets flag
    cyc(1, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    chk("R2 flag", rdData[0], 1);
    // R4 stretched release
    for (int i = 0; i < HOLD + 2; i++) cyc(0, 0, 0, 0, 0, 0, "R4");
    // R4 restart during hold
    cyc(1, 0, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, "R4");
    for (int i = 0; i < HOLD + 2; i++) cyc(0, 0, 0, 0, 0, 0, "R4");
    // R6 read with fault present: stays set
    cyc(1, 0, 1, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    chk("R6 flag kept", rdData[0], 1);
    // R5 read after fault gone clears
    cyc(0, 0, 1, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, "R5");
    chk("R5 flag cleared", rdData[0], 0);
    // R3 low-supply flag, R5 for lvd while still low
    cyc(0, 1, 0, 0, 0, 1, "R3");
    cyc(0, 1, 1, 0, 0, 2, "R5");
    cyc(0, 0, 0, 0, 0, 2, "R5");
    chk("R5 lvd kept", rdData[1], 1);
    // R7 sleep freezes, R8 sleep read clears
    cyc(0, 0, 0, 0, 0, 3, "R7");
    cyc(0, 1, 0, 0, 0, 3, "R7");
    cyc(0, 1, 1, 0, 0, 3, "R8");
    cyc(0, 1, 0, 0, 0, 3, "R8");
    chk("R8 lvd cleared", rdData[1], 0);
    cyc(0, 1, 0, 0, 0, 3, "R7");
    chk("R7 lvd ignored", rdData[1], 0);
    // R9 config: low threshold, monSel=1, en1=0 -> monitor off
    cyc(0, 0, 0, 1, 4'b0111, 0, "R9");
    cyc(1, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 0, 0, 0, 0, "R9");
    chk("R9 no reset when off", rstOutN, 1);
    cyc(0, 0, 0, 1, 4'b1010, 0, "R9");
    cyc(1, 0, 0, 0, 0, 0, "R9");

    // R10 random mixed stream
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4000; i++) begin
      bit bR, bL, rd, wr;
      bit [3:0] wd;
      bit [1:0] md;
      bR = ($urandom % 100) < ((i / 40) % 2 ? 40 : 3);
      bL = ($urandom % 100) < 20;
      rd = ($urandom % 100) < 25;
      wr = ($urandom % 100) < 2;
      wd = 4'($urandom);
      md = 2'($urandom);
      cyc(bR, bL, rd, wr, wd, md, "R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule